// File: doc/BRIEF.md
# Selectable Zero-Substitution AMI Line Encoder

This block sits on the transmit side of a coaxial line interface. It takes binary data, one bit per transmit clock, and turns it into two rail bits, one that marks a positive pulse and one that marks a negative pulse, for an alternate-mark-inversion line driver. Ones alternate in polarity. Long runs of zeros are replaced by substitution patterns that carry a deliberate bipolar violation, so the far end keeps enough pulses to hold clock recovery. One input chooses the substitution code: three-zero substitution for the 44.736 and 51.84 Mbit/s rates, or four-zero substitution for the 34.368 Mbit/s rate.

A bypass input switches off the encoder. The rail bits supplied from outside then pass straight to the outputs, for framers that do their own line coding. A remote-loopback input takes the rail bits coming from the receive side and sends them back out, so the far end can run a bit-continuity test. A transmit-enable input holds both outputs low. All logic runs on one clock with a synchronous active-high reset.

Top module: `zsub_line_encoder`

## Requirements
- R1: While `rst` is high, both outputs are low one cycle later. After reset the first encoded pulse (a mark or a B substitution pulse) is positive.
- R2: `pos_out` and `neg_out` are never high in the same cycle. In bypass or loopback, a source with both rails high gives both outputs low.
- R3: In encoding mode (`raw_mode`=0, `loop_remote`=0), the bit on `pos_in` sampled at one clock edge appears on the rails after 3 more edges with `code_sel`=0, or after 4 more edges with `code_sel`=1. Successive marks alternate polarity.
- R4: With `code_sel`=0, every run of three zeros is sent as 00V if an odd number of pulses has been sent since the last V, and as B0V otherwise. B takes the polarity opposite the previous pulse and V takes the same polarity as the previous pulse.
- R5: With `code_sel`=1, every run of four zeros is sent as 000V when the pulse count since the last V is odd, and as B00V when it is even. The polarity rules for B and V are the same as in R4.
- R6: In steady encoding, the rails never show more than 2 consecutive zero cycles with `code_sel`=0, or more than 3 with `code_sel`=1.
- R7: With `raw_mode`=1 and `loop_remote`=0, `pos_in` and `neg_in` are copied to `pos_out` and `neg_out` one edge after they are sampled.
- R8: In encoding mode `neg_in` is ignored: the rails depend on `pos_in` alone.
- R9: With `loop_remote`=1, `rx_pos` and `rx_neg` go to the outputs one edge later, whatever `raw_mode` and the transmit inputs are.
- R10: When `tx_on` is low at an edge, both outputs are low after that edge. The encoder keeps running meanwhile, and its polarity and substitution state stay in step with the data.
- R11: Bypass and loopback empty the lookahead and clear the substitution parity. On return to encoding, the outputs stay low for 3 (or 4) cycles, and the count of pulses since the last V starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| code_sel | input | 1 | 0 = three-zero substitution, 1 = four-zero substitution |
| raw_mode | input | 1 | 1 = bypass the encoder and pass the external rails |
| loop_remote | input | 1 | 1 = send the receive-side rails back out |
| tx_on | input | 1 | 1 = outputs active, 0 = both outputs held low |
| pos_in | input | 1 | Binary data when encoding; positive rail in bypass |
| neg_in | input | 1 | Negative rail in bypass; ignored when encoding |
| rx_pos | input | 1 | Positive rail recovered by the receiver |
| rx_neg | input | 1 | Negative rail recovered by the receiver |
| pos_out | output | 1 | Positive-pulse rail to the line driver |
| neg_out | output | 1 | Negative-pulse rail to the line driver |

## Verification
The hardest case to reach is a zero run that has to take the B-then-V form right after a substitution has already fired. It needs a particular parity of pulses since the previous V, and a particular polarity of the last pulse, both held in state that cannot be seen at the ports. The stimulus uses long stretches of data weighted toward zeros, including forced runs of ten or more zeros, in both codes. It also leaves bypass right into a run of ones, which resets the parity and fills the lookahead afresh. A behavioural queue model in the bench predicts every rail bit from the requirements, and the bench compares it with the outputs on every cycle.

// File: rtl/zsub_pkg.sv
package zsub_pkg;

    typedef enum logic [2:0] {
        SYM_FILL,
        SYM_ZERO,
        SYM_MARK,
        SYM_BSUB,
        SYM_VSUB
    } sym_t;

    typedef enum logic {
        CODE_RUN3 = 1'b0,
        CODE_RUN4 = 1'b1
    } code_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam int RUN3_LEN   = 3;
    localparam int RUN4_LEN   = 4;
    localparam int LOOK_DEPTH = (RUN3_LEN > RUN4_LEN) ? RUN3_LEN : RUN4_LEN;

    function automatic int run_len(code_t c);
        return (c == CODE_RUN4) ? RUN4_LEN : RUN3_LEN;
    endfunction

endpackage

// File: rtl/zsub_rail_select.sv
module zsub_rail_select
    import zsub_pkg::*;
(
    input  logic  loop_remote,
    input  logic  pos_in,
    input  logic  neg_in,
    input  logic  rx_pos,
    input  logic  rx_neg,
    output rail_t src
);

    always_comb begin
        if (loop_remote) begin
            src.pos = rx_pos;
            src.neg = rx_neg;
        end else begin
            src.pos = pos_in;
            src.neg = neg_in;
        end
    end

endmodule

// File: rtl/zsub_lookahead.sv
module zsub_lookahead
    import zsub_pkg::*;
#(
    parameter int DEPTH = LOOK_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  code_t code,
    input  logic  data_bit,
    output sym_t  tap
);

    sym_t slots [DEPTH];
    sym_t nxt   [DEPTH];
    logic odd_q;
    logic hit;
    int   k;

    always_comb begin
        k   = run_len(code);
        hit = ~data_bit;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (i < k - 1 && slots[i] != SYM_ZERO) begin
                hit = 1'b0;
            end
        end

        if (hit) begin
            nxt[0] = SYM_VSUB;
        end else if (data_bit) begin
            nxt[0] = SYM_MARK;
        end else begin
            nxt[0] = SYM_ZERO;
        end

        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = slots[i-1];
            if (hit && !odd_q && i == k - 1) begin
                nxt[i] = SYM_BSUB;
            end
        end

        tap = SYM_FILL;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == k - 1) begin
                tap = slots[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= SYM_FILL;
            end
            odd_q <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= nxt[i];
            end
            if (hit) begin
                odd_q <= 1'b0;
            end else if (data_bit) begin
                odd_q <= ~odd_q;
            end
        end
    end

endmodule

// File: rtl/zsub_polarity.sv
module zsub_polarity
    import zsub_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  encode_en,
    input  logic  tx_on,
    input  sym_t  tap,
    input  rail_t src,
    output logic  pos_out,
    output logic  neg_out
);

    logic  last_neg_q;
    logic  last_neg_d;
    rail_t enc_r;
    rail_t sel_r;

    always_comb begin
        enc_r      = '0;
        last_neg_d = last_neg_q;
        case (tap)
            SYM_MARK, SYM_BSUB: begin
                enc_r.pos  = last_neg_q;
                enc_r.neg  = ~last_neg_q;
                last_neg_d = ~last_neg_q;
            end
            SYM_VSUB: begin
                enc_r.pos = ~last_neg_q;
                enc_r.neg = last_neg_q;
            end
            default: begin
                enc_r = '0;
            end
        endcase

        if (encode_en) begin
            sel_r = enc_r;
        end else begin
            sel_r.pos = src.pos & ~src.neg;
            sel_r.neg = src.neg & ~src.pos;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_out    <= 1'b0;
            neg_out    <= 1'b0;
            last_neg_q <= 1'b1;
        end else begin
            pos_out <= tx_on & sel_r.pos;
            neg_out <= tx_on & sel_r.neg;
            if (encode_en) begin
                last_neg_q <= last_neg_d;
            end
        end
    end

endmodule

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder
    import zsub_pkg::*;
#(
    parameter int DEPTH = LOOK_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic code_sel,
    input  logic raw_mode,
    input  logic loop_remote,
    input  logic tx_on,
    input  logic pos_in,
    input  logic neg_in,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic pos_out,
    output logic neg_out
);

    logic  encode_en;
    rail_t src;
    sym_t  tap;

    assign encode_en = ~raw_mode & ~loop_remote;

    zsub_rail_select u_sel (
        .loop_remote (loop_remote),
        .pos_in      (pos_in),
        .neg_in      (neg_in),
        .rx_pos      (rx_pos),
        .rx_neg      (rx_neg),
        .src         (src)
    );

    zsub_lookahead #(.DEPTH(DEPTH)) u_look (
        .clk      (clk),
        .rst      (rst),
        .flush    (~encode_en),
        .code     (code_t'(code_sel)),
        .data_bit (pos_in),
        .tap      (tap)
    );

    zsub_polarity u_pol (
        .clk       (clk),
        .rst       (rst),
        .encode_en (encode_en),
        .tx_on     (tx_on),
        .tap       (tap),
        .src       (src),
        .pos_out   (pos_out),
        .neg_out   (neg_out)
    );

endmodule

// File: rtl/zsub_line_encoder_chk.sv
module zsub_line_encoder_chk
    import zsub_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic code_sel,
    input logic raw_mode,
    input logic loop_remote,
    input logic tx_on,
    input logic pos_in,
    input logic neg_in,
    input logic rx_pos,
    input logic rx_neg,
    input logic pos_out,
    input logic neg_out
);

    logic [3:0] steady_q;
    logic [2:0] zrun_q;
    logic       code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            steady_q <= '0;
            zrun_q   <= '0;
            code_q   <= 1'b0;
        end else begin
            code_q <= code_sel;
            if (!raw_mode && !loop_remote && tx_on && code_sel == code_q) begin
                steady_q <= (steady_q == 4'hF) ? steady_q : steady_q + 4'd1;
            end else begin
                steady_q <= '0;
            end
            if (pos_out || neg_out) begin
                zrun_q <= '0;
            end else begin
                zrun_q <= (zrun_q == 3'd7) ? zrun_q : zrun_q + 3'd1;
            end
        end
    end

    a_r2_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pos_out && neg_out));

    a_r10_tx_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_on |=> !(pos_out || neg_out));

    a_r7_raw_pass_pos: assert property (@(posedge clk) disable iff (rst)
        (raw_mode && !loop_remote && tx_on && pos_in && !neg_in) |=> (pos_out && !neg_out));

    a_r9_loop_pass_neg: assert property (@(posedge clk) disable iff (rst)
        (loop_remote && tx_on && rx_neg && !rx_pos) |=> (neg_out && !pos_out));

    a_r6_zero_run_bound: assert property (@(posedge clk) disable iff (rst)
        (steady_q == 4'hF) |-> (int'(zrun_q) < run_len(code_t'(code_sel))));

endmodule

bind zsub_line_encoder zsub_line_encoder_chk u_chk (.*);

// File: tb/zsub_line_encoder_bench.sv
module zsub_line_encoder_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic code_sel = 1'b0;
    logic raw_mode = 1'b0;
    logic loop_remote = 1'b0;
    logic tx_on = 1'b1;
    logic pos_in = 1'b0;
    logic neg_in = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic pos_out;
    logic neg_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state: 0 zero, 1 mark, 2 B, 3 V, -1 nothing
    int  q[$];
    int  pend = -1;
    int  par = 0;
    bit  lastneg = 1;
    bit  ep = 0;
    bit  en = 0;
    string tag = "R1";
    bit  track = 0;
    int  zr = 0;
    int  maxzr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zsub_line_encoder u_zsub_line_encoder (
        .clk         (clk),
        .rst         (rst),
        .code_sel    (code_sel),
        .raw_mode    (raw_mode),
        .loop_remote (loop_remote),
        .tx_on       (tx_on),
        .pos_in      (pos_in),
        .neg_in      (neg_in),
        .rx_pos      (rx_pos),
        .rx_neg      (rx_neg),
        .pos_out     (pos_out),
        .neg_out     (neg_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic model();
        if (rst) begin
            q.delete(); pend = -1; par = 0; lastneg = 1; ep = 0; en = 0;
        end else if (raw_mode || loop_remote) begin
            bit p = loop_remote ? rx_pos : pos_in;
            bit n = loop_remote ? rx_neg : neg_in;
            ep = tx_on & p & !n;
            en = tx_on & n & !p;
            q.delete(); pend = -1; par = 0;
        end else begin
            int k = code_sel ? 4 : 3;
            bit op = 0;
            bit on = 0;
            bit allz = 1;
            if (pend == 1 || pend == 2) begin
                if (lastneg) op = 1; else on = 1;
                lastneg = !lastneg;
            end else if (pend == 3) begin
                if (lastneg) on = 1; else op = 1;
            end
            ep = op & tx_on;
            en = on & tx_on;
            q.push_back(pos_in ? 1 : 0);
            foreach (q[i]) if (q[i] != 0) allz = 0;
            if (q.size() == k && allz) begin
                if (par != 0) q[k-1] = 3;
                else begin q[0] = 2; q[k-1] = 3; end
                par = 0;
            end else if (pos_in) begin
                par = par ^ 1;
            end
            pend = -1;
            if (q.size() == k) pend = q.pop_front();
        end
    endtask

    task automatic step();
        model();
        @(posedge clk);
        #1;
        chk(pos_out === ep && neg_out === en, tag, "rails {pos,neg}",
            {pos_out, neg_out}, {ep, en});
        chk(!(pos_out && neg_out), "R2", "both rails high", {pos_out, neg_out}, 0);
        if (track) begin
            if (!pos_out && !neg_out) zr++; else zr = 0;
            if (zr > maxzr) maxzr = zr;
        end
    endtask

    task automatic run_random(input int n, input int warm);
        for (int i = 0; i < n; i++) begin
            pos_in = ($urandom_range(0, 3) == 0);
            neg_in = $urandom_range(0, 1);
            track = (i >= warm);
            step();
        end
        track = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) step();
        rst = 0;

        // R1 R3: first mark positive, three-edge latency in run-3 code
        tag = "R3";
        pos_in = 1; step();
        pos_in = 0;
        for (int i = 0; i < 3; i++) step();
        chk(pos_out && !neg_out, "R1 R3", "first mark positive after 3 edges",
            {pos_out, neg_out}, 2);

        // R4 R8: run-3 code, neg_in toggling is ignored
        tag = "R4 R8";
        run_random(60, 12);
        pos_in = 0;
        for (int i = 0; i < 12; i++) step();
        run_random(60, 0);
        chk(maxzr <= 2, "R6", "longest zero run in run-3 code", maxzr, 2);

        // R7 R2: bypass
        tag = "R7";
        raw_mode = 1;
        for (int i = 0; i < 30; i++) begin
            pos_in = $urandom_range(0, 1);
            neg_in = $urandom_range(0, 1);
            step();
        end
        pos_in = 1; neg_in = 1; step();
        chk(!pos_out && !neg_out, "R2", "bypass with both rails high", {pos_out, neg_out}, 0);

        // R11 R5: switch code during bypass, then return to encoding
        code_sel = 1;
        step();
        raw_mode = 0;
        tag = "R5 R11";
        pos_in = 1; neg_in = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(!pos_out && !neg_out, "R11", "quiet while lookahead refills",
                {pos_out, neg_out}, 0);
        end
        pos_in = 0;
        for (int i = 0; i < 10; i++) step();
        maxzr = 0; zr = 0;
        tag = "R5";
        run_random(80, 12);
        pos_in = 0;
        track = 1;
        for (int i = 0; i < 14; i++) step();
        track = 0;
        run_random(60, 0);
        chk(maxzr <= 3, "R6", "longest zero run in run-4 code", maxzr, 3);

        // R3: four-edge latency in run-4 code (fresh start through bypass)
        raw_mode = 1; step();
        raw_mode = 0;
        tag = "R3";
        pos_in = 1; step();
        pos_in = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(!pos_out && !neg_out, "R3", "no pulse before 4 edges", {pos_out, neg_out}, 0);
        end
        step();
        chk(pos_out || neg_out, "R3", "pulse after 4 edges", {pos_out, neg_out}, 1);

        // R9: remote loopback overrides bypass and transmit inputs
        tag = "R9";
        loop_remote = 1;
        for (int i = 0; i < 30; i++) begin
            raw_mode = $urandom_range(0, 1);
            pos_in = $urandom_range(0, 1);
            neg_in = $urandom_range(0, 1);
            rx_pos = $urandom_range(0, 1);
            rx_neg = $urandom_range(0, 1);
            step();
        end
        loop_remote = 0; raw_mode = 0;

        // R10: transmitter disabled while encoder keeps running
        tag = "R10";
        tx_on = 0;
        run_random(25, 25);
        tag = "R5 R10";
        tx_on = 1;
        run_random(40, 40);

        // R4: back to run-3 code through a reset
        rst = 1; tag = "R1"; step(); step();
        rst = 0; code_sel = 0; tag = "R4";
        pos_in = 0;
        for (int i = 0; i < 12; i++) step();
        run_random(40, 40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

endmodule